// File: doc/BRIEF.md
# Serial Receiver with Two-Word Holding Queue

This block recovers asynchronous serial frames from a single receive line. It uses a tick that pulses sixteen times per bit period. A frame begins with a low start bit and carries 8 or 9 data bits, least significant bit first, followed by one stop bit. Each data bit is decided by a majority vote of three samples taken around the middle of the bit. When the stop bit has been sampled, the assembled word is moved into a two-entry queue. Each queue entry stores the data byte, the optional ninth bit and a framing-error flag for that word.

The consumer reads the entry at the head of the queue from the read outputs and removes it by pulsing `pop`. A data-available flag stays high while the queue holds anything. An interrupt output is this flag gated by an enable input. If a word finishes while the queue is full, the word is dropped and a sticky overrun flag is raised. From then on, nothing more enters the queue until the receive enable is taken low and then high again. The queue contents stay readable during this time.

Top module: `uart_rx_fifo2`

## Requirements
- R1: A falling edge on the line, seen at a tick, starts a frame and is sample 0. The line is checked again at sample 7 (the eighth sample). If it is high there, the frame is treated as a false start, the receiver returns to idle and no word is produced.
- R2: While `rx_en` is low, the receiver stays idle and captures no words.
- R3: Data bits arrive LSB first. Each bit is the majority of samples 7, 8 and 9 of its bit period. With `nine_bit_mode`=1 there are 9 data bits: bits 7:0 appear on `rd_data` and bit 8 on `rd_bit9`. With `nine_bit_mode`=0 there are 8 data bits and `rd_bit9` reads 0.
- R4: A stop bit sampled as 0 sets `rd_ferr`=1 for that word's entry. A stop bit sampled as 1 gives `rd_ferr`=0.
- R5: When the stop bit has been sampled, the word enters the queue if there is room. The queue holds two words, so two words can wait while a third is arriving.
- R6: If the queue is full and not being popped when a word's stop bit is sampled, `ovr_err` is set and that word is discarded.
- R7: While `ovr_err` is high, no word enters the queue.
- R8: `ovr_err` stays high while `rx_en` stays high. It is cleared only by driving `rx_en` low and then high again.
- R9: `rd_data`, `rd_bit9` and `rd_ferr` show the head entry. A pop replaces them with the next entry's values.
- R10: `data_avail` goes high when a word enters the queue. It falls only when a pop leaves the queue empty. A pop on an empty queue has no effect.
- R11: `irq` is high exactly when `data_avail` and `irq_en` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_in | input | 1 | Serial receive line, idles high |
| os_tick | input | 1 | One-cycle pulse, 16 per bit period |
| rx_en | input | 1 | Receive enable; a low level resets the receive logic |
| nine_bit_mode | input | 1 | 1 selects 9 data bits per frame; static during a frame |
| irq_en | input | 1 | Interrupt enable |
| pop | input | 1 | Removes the head entry |
| rd_data | output | 8 | Head entry data byte |
| rd_bit9 | output | 1 | Head entry ninth bit |
| rd_ferr | output | 1 | Head entry framing-error flag |
| data_avail | output | 1 | Queue is not empty |
| ovr_err | output | 1 | Sticky overrun flag |
| irq | output | 1 | data_avail gated by irq_en |

## Verification
The hardest state to reach is a third word completing while two words are still waiting. Reaching it takes three back-to-back frames with no pop, and each frame spans hundreds of clocks. The bench sends three frames whose status fields differ, then confirms three things: the overrun flag is set, the head still shows the first word, and popping brings out the second word with its own framing flag. It then sends a fourth frame while overrun is held, to show that nothing enters the queue, and toggles the enable to show recovery.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  localparam int DATA_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } rxq_state_e;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              bit9;
    logic              ferr;
  } rxq_entry_t;

  // Two-of-three vote on the samples taken around the bit centre
  function automatic logic maj3(input logic [2:0] v);
    return (v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]);
  endfunction

  // Bits enter at the top of the shifter; an 8-bit frame ends one place higher
  function automatic rxq_entry_t pack_word(input logic [DATA_W:0] sh,
                                           input logic nine,
                                           input logic bad_stop);
    rxq_entry_t e;
    e.data = nine ? sh[DATA_W-1:0] : sh[DATA_W:1];
    e.bit9 = nine ? sh[DATA_W] : 1'b0;
    e.ferr = bad_stop;
    return e;
  endfunction

endpackage

// File: rtl/rxq_sampler.sv
module rxq_sampler
  import rxq_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_en,
  input  logic       os_tick,
  input  logic       rx_in,
  input  logic       nine_bit,
  output logic       busy,
  output logic       word_done,
  output rxq_entry_t word
);

  localparam int SW  = $clog2(OSR);
  localparam int MID = OSR / 2 - 1;

  logic [1:0]      sync_q;
  logic            rx_s;
  logic            prev_lvl;
  logic [SW-1:0]   smp;
  logic [3:0]      bitcnt;
  logic [2:0]      votes;
  logic [DATA_W:0] shreg;
  rxq_state_e      state;

  wire       in_window = (smp == SW'(MID)) || (smp == SW'(MID + 1)) ||
                         (smp == SW'(MID + 2));
  wire       bit_end   = (smp == SW'(OSR - 1));
  wire [3:0] last_bit  = nine_bit ? 4'd8 : 4'd7;

  assign rx_s = sync_q[1];
  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q    <= 2'b11;
      prev_lvl  <= 1'b1;
      smp       <= '0;
      bitcnt    <= '0;
      votes     <= '0;
      shreg     <= '0;
      state     <= ST_IDLE;
      word_done <= 1'b0;
      word      <= '0;
    end else begin
      sync_q    <= {sync_q[0], rx_in};
      word_done <= 1'b0;
      if (!rx_en) begin
        state    <= ST_IDLE;
        prev_lvl <= 1'b1;
        smp      <= '0;
      end else if (os_tick) begin
        prev_lvl <= rx_s;
        smp      <= smp + 1'b1;
        if (in_window) votes <= {votes[1:0], rx_s};
        case (state)
          ST_IDLE: begin
            if (prev_lvl && !rx_s) begin
              state <= ST_START;
              smp   <= SW'(1);
            end else begin
              smp <= '0;
            end
          end
          ST_START: begin
            if (smp == SW'(MID) && rx_s) begin
              state <= ST_IDLE;
            end else if (bit_end) begin
              state  <= ST_DATA;
              bitcnt <= '0;
            end
          end
          ST_DATA: begin
            if (bit_end) begin
              shreg  <= {maj3(votes), shreg[DATA_W:1]};
              bitcnt <= bitcnt + 1'b1;
              if (bitcnt == last_bit) state <= ST_STOP;
            end
          end
          ST_STOP: begin
            if (smp == SW'(MID + 3)) begin
              word      <= pack_word(shreg, nine_bit, !maj3(votes));
              word_done <= 1'b1;
              state     <= ST_IDLE;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo
  import rxq_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           rx_en,
  input  logic                           word_done,
  input  rxq_entry_t                     word,
  input  logic                           pop,
  output rxq_entry_t                     head,
  output logic [$clog2(DEPTH+1)-1:0]     count,
  output logic                           push_ok,
  output logic                           ovr_set,
  output logic                           ovr
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  rxq_entry_t    mem [DEPTH];
  logic [PW-1:0] wr_ptr;
  logic [PW-1:0] rd_ptr;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  wire pop_ok = pop && (count != '0);
  wire room   = (count < CW'(DEPTH)) || pop_ok;

  assign push_ok = word_done && !ovr && room;
  assign ovr_set = word_done && !ovr && !room;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovr    <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (push_ok) begin
        mem[wr_ptr] <= word;
        wr_ptr      <= nxt(wr_ptr);
      end
      if (pop_ok) rd_ptr <= nxt(rd_ptr);
      count <= count + CW'(push_ok) - CW'(pop_ok);
      if (!rx_en)       ovr <= 1'b0;
      else if (ovr_set) ovr <= 1'b1;
    end
  end

endmodule

// File: rtl/uart_rx_fifo2.sv
module uart_rx_fifo2
  import rxq_pkg::*;
#(
  parameter int OSR   = 16,
  parameter int DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_in,
  input  logic              os_tick,
  input  logic              rx_en,
  input  logic              nine_bit_mode,
  input  logic              irq_en,
  input  logic              pop,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_bit9,
  output logic              rd_ferr,
  output logic              data_avail,
  output logic              ovr_err,
  output logic              irq
);

  localparam int CW = $clog2(DEPTH + 1);

  // Named internal events, observed by the bound checker
  logic          busy;
  logic          word_done;
  logic          push_ok;
  logic          ovr_set;
  logic [CW-1:0] fifo_count;
  rxq_entry_t    word;
  rxq_entry_t    head;

  rxq_sampler #(.OSR(OSR)) u_smp (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_en    (rx_en),
    .os_tick  (os_tick),
    .rx_in    (rx_in),
    .nine_bit (nine_bit_mode),
    .busy     (busy),
    .word_done(word_done),
    .word     (word)
  );

  rxq_fifo #(.DEPTH(DEPTH)) u_q (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_en    (rx_en),
    .word_done(word_done),
    .word     (word),
    .pop      (pop),
    .head     (head),
    .count    (fifo_count),
    .push_ok  (push_ok),
    .ovr_set  (ovr_set),
    .ovr      (ovr_err)
  );

  assign rd_data    = head.data;
  assign rd_bit9    = head.bit9;
  assign rd_ferr    = head.ferr;
  assign data_avail = (fifo_count != '0);
  assign irq        = data_avail & irq_en;

endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
  parameter int DEPTH = 2,
  parameter int CW    = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_en,
  input logic          pop,
  input logic          irq_en,
  input logic          busy,
  input logic          word_done,
  input logic          push_ok,
  input logic [CW-1:0] fifo_count,
  input logic          ovr_err,
  input logic          data_avail,
  input logic          irq
);

  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !busy); // R2

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= CW'(DEPTH)); // R5

  AST_OVR_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && word_done && !ovr_err && fifo_count == CW'(DEPTH) && !pop) |=> ovr_err); // R6

  AST_NO_XFER_IN_OVR: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_err |-> !push_ok); // R7

  AST_OVR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_err && rx_en) |=> ovr_err); // R8

  AST_AVAIL_ON_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok |=> data_avail); // R10

  AST_EMPTY_ON_LAST_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && fifo_count == CW'(1) && !push_ok) |=> !data_avail); // R10

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq); // R11

endmodule

bind uart_rx_fifo2 rxq_checker #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rx_en     (rx_en),
  .pop       (pop),
  .irq_en    (irq_en),
  .busy      (busy),
  .word_done (word_done),
  .push_ok   (push_ok),
  .fifo_count(fifo_count),
  .ovr_err   (ovr_err),
  .data_avail(data_avail),
  .irq       (irq)
);

// File: tb/uart_rx_fifo2_test.sv
module uart_rx_fifo2_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_in = 1'b1;
  logic       os_tick;
  logic       rx_en = 1'b0;
  logic       nine_bit_mode = 1'b0;
  logic       irq_en = 1'b1;
  logic       pop = 1'b0;
  logic [7:0] rd_data;
  logic       rd_bit9, rd_ferr, data_avail, ovr_err, irq;

  int n_chk  = 0;
  int n_fail = 0;
  logic [1:0] tdiv = '0;

  always #5 clk = ~clk;

  // 16 ticks per bit, one tick every 4 clocks: a bit lasts 64 clocks
  always_ff @(posedge clk) tdiv <= tdiv + 1'b1;
  assign os_tick = (tdiv == 2'd3);

  uart_rx_fifo2 uut (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .os_tick(os_tick),
    .rx_en(rx_en), .nine_bit_mode(nine_bit_mode), .irq_en(irq_en),
    .pop(pop), .rd_data(rd_data), .rd_bit9(rd_bit9), .rd_ferr(rd_ferr),
    .data_avail(data_avail), .ovr_err(ovr_err), .irq(irq)
  );

  // {nine, stop level, 9-bit payload}
  localparam logic [10:0] VEC [6] = '{
    {1'b0, 1'b1, 9'h0A5},
    {1'b0, 1'b1, 9'h03C},
    {1'b0, 1'b0, 9'h0FF},
    {1'b1, 1'b1, 9'h1C3},
    {1'b1, 1'b1, 9'h081},
    {1'b1, 1'b0, 9'h100}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive_bit(input logic b);
    rx_in = b;
    repeat (64) @(negedge clk);
  endtask

  task automatic send_frame(input logic [8:0] d, input logic nine, input logic stopb);
    drive_bit(1'b0);
    for (int i = 0; i < (nine ? 9 : 8); i++) drive_bit(d[i]);
    drive_bit(stopb);
    drive_bit(1'b1);
  endtask

  task automatic do_pop();
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 reset avail", data_avail, 0);
    check("R8 reset ovr", ovr_err, 0);
    check("R11 reset irq", irq, 0);

    // R2: frame sent while disabled is ignored
    send_frame(9'h055, 1'b0, 1'b1);
    check("R2 disabled no word", data_avail, 0);
    rx_en = 1'b1;
    repeat (32) @(negedge clk);

    // Table walk: R3 R4 R9 R10 R11
    for (int k = 0; k < 6; k++) begin
      logic       nine, stopb;
      logic [8:0] d;
      {nine, stopb, d} = VEC[k];
      nine_bit_mode = nine;
      send_frame(d, nine, stopb);
      check("R5 word queued", data_avail, 1);
      check("R3 data", rd_data, d[7:0]);
      check("R3 bit9", rd_bit9, nine ? d[8] : 1'b0);
      check("R4 ferr", rd_ferr, !stopb);
      check("R11 irq on", irq, 1);
      do_pop();
      check("R10 avail cleared", data_avail, 0);
    end

    // R10: pop on empty has no effect
    do_pop();
    check("R10 empty pop", data_avail, 0);
    nine_bit_mode = 1'b0;
    send_frame(9'h011, 1'b0, 1'b1);
    check("R10 after empty pop", rd_data, 8'h11);
    irq_en = 1'b0;
    @(negedge clk);
    check("R11 irq masked", irq, 0);
    irq_en = 1'b1;
    do_pop();

    // R1: short low pulse is a false start
    rx_in = 1'b0;
    repeat (16) @(negedge clk);
    rx_in = 1'b1;
    repeat (400) @(negedge clk);
    check("R1 false start", data_avail, 0);
    send_frame(9'h0E7, 1'b0, 1'b1);
    check("R1 recovers", rd_data, 8'hE7);
    do_pop();

    // R5 R6 R9: three frames, no pop
    send_frame(9'h001, 1'b0, 1'b0);
    send_frame(9'h002, 1'b0, 1'b1);
    check("R5 two held no ovr", ovr_err, 0);
    send_frame(9'h003, 1'b0, 1'b1);
    check("R6 overrun set", ovr_err, 1);
    check("R9 head first", rd_data, 8'h01);
    check("R9 head ferr", rd_ferr, 1);
    do_pop();
    check("R9 next data", rd_data, 8'h02);
    check("R9 next ferr", rd_ferr, 0);
    do_pop();
    check("R6 third discarded", data_avail, 0);

    // R7: nothing enters while overrun; R8 sticky
    send_frame(9'h044, 1'b0, 1'b1);
    check("R7 blocked", data_avail, 0);
    check("R8 sticky", ovr_err, 1);
    rx_en = 1'b0;
    repeat (4) @(negedge clk);
    rx_en = 1'b1;
    repeat (4) @(negedge clk);
    check("R8 cleared", ovr_err, 0);
    send_frame(9'h066, 1'b0, 1'b1);
    check("R8 receiving again", rd_data, 8'h66);
    check("R8 avail again", data_avail, 1);
    do_pop();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule